// File: doc/BRIEF.md
# Timekeeping Register Bus Interface

This block is the byte-wide parallel bus front end of a battery-backed clock/calendar that occupies the eight highest locations of an 8K x 8 address space. It decodes the active-low chip-select, output-enable and write-enable strobes. It returns register contents for reads of those eight locations. For any lower address it raises a select for the external memory array and leaves the data bus to that array.

Two copies of the time coexist. The live counters advance once per second from a clock prescaler. A user-visible copy is what the bus reads and writes. The copy follows the counters every clock until software sets one of two hold bits in the control byte. The read-hold bit freezes a coherent snapshot while counting carries on underneath. The write-hold bit stops tracking and lets software compose a new time field by field. Clearing the write-hold bit moves every field into the counters in one clock and restarts the prescaler. The control byte also carries the century. The seconds byte carries an oscillator-stop bit. The weekday byte carries a read-only battery flag and a frequency-test enable that drives a 512 Hz square wave.

Top module: `tkr_bus`

## Requirements
- R1: With chip-select low, an address whose upper ADDR_W-3 bits are not all ones raises `mem_sel_o` and the block never drives data for it. With chip-select high, neither `mem_sel_o` nor `data_oe_o` is raised.
- R2: `data_oe_o` is high exactly when chip-select is low, output-enable is low, write-enable is high and the address lies in the window.
- R3: Offsets 0..7 select control, seconds, minutes, hour, weekday, date, month and year. Control byte: bit 7 write-hold, bit 6 read-hold, bits 5:0 BCD century (tens in 5:4). Seconds: bit 7 oscillator stop. Weekday: bit 7 battery flag, bit 6 frequency-test enable, bits 2:0 weekday 1..7.
- R4: Unused bits are dropped on write and read back as zero: minutes bit 7, hour bits 7:6, weekday bits 5:3, date bits 7:6, month bits 7:5.
- R5: While write-hold is 1, writes to time fields land in the user copy and the copy does not track the counters. While write-hold is 0, writes to time fields are ignored.
- R6: A write that moves write-hold from 1 to 0 loads every user field, including any century in that same byte, into the counters at that clock. It also restarts the prescaler, so the next second advances 2^PRE_W clocks later.
- R7: Setting read-hold freezes the user copy with a coherent snapshot. Counting continues, and clearing read-hold shows the current time.
- R8: Counting is BCD. Seconds and minutes wrap at 59. Hours wrap at 23. Weekday runs 1..7. Month runs 01..12. Year wraps 99 to 00 and carries into the century, which runs 00..39.
- R9: The last date of a month is 31 or 30, or 28 for February. February has 29 when the year is divisible by four, except that year 00 is leap only when the century is divisible by four.
- R10: Oscillator stop = 1 halts the prescaler and the counters. Clearing it resumes from the held prescaler count. The bit can be written whatever the state of write-hold.
- R11: The battery flag reads the `bat_flag_i` pin. Writes to that bit are ignored.
- R12: With frequency test set and the oscillator running, `ftest_o` is a square wave of period 2^(PRE_W-9) clocks (512 Hz). Otherwise it is 0.
- R13: After reset the registers read 20 00-01-01, weekday 1, 00:00:00, with both hold bits, oscillator stop and frequency test at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the prescaler source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| ce_ni | input | 1 | Chip-select, active low |
| oe_ni | input | 1 | Output-enable, active low |
| we_ni | input | 1 | Write-enable, active low |
| bat_flag_i | input | 1 | Battery status shown in the weekday byte |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Drive enable for the data bus |
| mem_sel_o | output | 1 | Select for the external memory array |
| ftest_o | output | 1 | Frequency-test square wave |

## Verification
The assertions check on every cycle these properties:
- the memory select and the data drive are never raised together;
- the user copy stays still under either hold bit unless a permitted write arrives;
- a load places exactly the presented values in the counters;
- the counters move only on a prescaler tick;
- seconds wrap into minutes;
- a stopped oscillator freezes the prescaler.

Only the bench's scenarios can show the rest:
- calendar correctness across every month end, the leap rules and the century carry;
- masking of unused bits;
- the timing of the first second after a load;
- the 512 Hz waveform;
- the ignored writes to time fields and to the battery flag.

// File: rtl/tkr_pkg.sv
package tkr_pkg;

  typedef struct packed {
    logic [5:0] cent;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } tk_time_t;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_SEC  = 3'd1,
    OFS_MIN  = 3'd2,
    OFS_HR   = 3'd3,
    OFS_DAY  = 3'd4,
    OFS_DATE = 3'd5,
    OFS_MON  = 3'd6,
    OFS_YR   = 3'd7
  } tk_ofs_e;

  localparam tk_time_t TK_RST_TIME = '{cent: 6'h20, yr: 8'h00, mon: 5'h01,
                                       date: 6'h01, day: 3'd1, hr: 6'h00,
                                       min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] mon,
                                            input logic [7:0] yr,
                                            input logic [5:0] cent);
    int   y;
    int   c;
    logic leap;
    y    = int'(yr[7:4]) * 10 + int'(yr[3:0]);
    c    = int'(cent[5:4]) * 10 + int'(cent[3:0]);
    leap = ((y % 4) == 0) && ((y != 0) || ((c % 4) == 0));
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/tkr_prescaler.sv
module tkr_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic ft_en_i,
  output logic tick_o,
  output logic ftest_o
);
  // bit whose half period is 1/1024 s
  localparam int FT_BIT = (PRE_W >= 10) ? PRE_W - 10 : 0;

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o  = run_i && !clear_i && (cnt_q == '1);
  assign ftest_o = ft_en_i && run_i && cnt_q[FT_BIT];

  a_r10_prescaler_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_i) && !$past(clear_i)) |-> $stable(cnt_q));

endmodule

// File: rtl/tkr_time_core.sv
module tkr_time_core
  import tkr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     load_i,
  input  tk_time_t load_val_i,
  output tk_time_t live_o
);
  tk_time_t live_q, nxt;

  always_comb begin
    nxt = live_q;
    if (tick_i) begin
      if (live_q.sec != 7'h59) nxt.sec = 7'(bcd_inc({1'b0, live_q.sec}));
      else begin
        nxt.sec = 7'h00;
        if (live_q.min != 7'h59) nxt.min = 7'(bcd_inc({1'b0, live_q.min}));
        else begin
          nxt.min = 7'h00;
          if (live_q.hr != 6'h23) nxt.hr = 6'(bcd_inc({2'b0, live_q.hr}));
          else begin
            nxt.hr  = 6'h00;
            nxt.day = (live_q.day == 3'd7) ? 3'd1 : live_q.day + 3'd1;
            if (live_q.date != month_last(live_q.mon, live_q.yr, live_q.cent))
              nxt.date = 6'(bcd_inc({2'b0, live_q.date}));
            else begin
              nxt.date = 6'h01;
              if (live_q.mon != 5'h12) nxt.mon = 5'(bcd_inc({3'b0, live_q.mon}));
              else begin
                nxt.mon = 5'h01;
                if (live_q.yr != 8'h99) nxt.yr = bcd_inc(live_q.yr);
                else begin
                  nxt.yr   = 8'h00;
                  nxt.cent = (live_q.cent == 6'h39) ? 6'h00
                                                    : 6'(bcd_inc({2'b0, live_q.cent}));
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     live_q <= TK_RST_TIME;
    else if (load_i) live_q <= load_val_i;
    else             live_q <= nxt;
  end

  assign live_o = live_q;

  a_r6_load_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> (live_q == $past(load_val_i)));

  a_r8_idle_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(load_i)) |-> $stable(live_q));

  a_r8_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_i) && !$past(load_i) && $past(live_q.sec) == 7'h59)
      |-> (live_q.sec == 7'h00 && live_q.min != $past(live_q.min)));

endmodule

// File: rtl/tkr_reg_file.sv
module tkr_reg_file
  import tkr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  tk_ofs_e  ofs_i,
  input  logic [7:0] wdata_i,
  input  logic     bat_flag_i,
  input  tk_time_t live_i,
  output logic [7:0] rdata_o,
  output logic     load_o,
  output tk_time_t load_val_o,
  output logic     osc_run_o,
  output logic     ft_en_o
);
  tk_time_t user_q, user_d;
  logic wr_hold_q, wr_hold_d;
  logic rd_hold_q, rd_hold_d;
  logic stop_q, stop_d;
  logic ft_q, ft_d;

  always_comb begin
    user_d    = user_q;
    wr_hold_d = wr_hold_q;
    rd_hold_d = rd_hold_q;
    stop_d    = stop_q;
    ft_d      = ft_q;
    if (!wr_hold_q && !rd_hold_q) user_d = live_i;
    if (wr_en_i) begin
      case (ofs_i)
        OFS_CTRL: begin
          wr_hold_d = wdata_i[7];
          rd_hold_d = wdata_i[6];
          if (wr_hold_q) user_d.cent = wdata_i[5:0];
        end
        OFS_SEC: begin
          stop_d = wdata_i[7];
          if (wr_hold_q) user_d.sec = wdata_i[6:0];
        end
        OFS_MIN:  if (wr_hold_q) user_d.min  = wdata_i[6:0];
        OFS_HR:   if (wr_hold_q) user_d.hr   = wdata_i[5:0];
        OFS_DAY: begin
          ft_d = wdata_i[6];
          if (wr_hold_q) user_d.day = wdata_i[2:0];
        end
        OFS_DATE: if (wr_hold_q) user_d.date = wdata_i[5:0];
        OFS_MON:  if (wr_hold_q) user_d.mon  = wdata_i[4:0];
        OFS_YR:   if (wr_hold_q) user_d.yr   = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q    <= TK_RST_TIME;
      wr_hold_q <= 1'b0;
      rd_hold_q <= 1'b0;
      stop_q    <= 1'b0;
      ft_q      <= 1'b0;
    end else begin
      user_q    <= user_d;
      wr_hold_q <= wr_hold_d;
      rd_hold_q <= rd_hold_d;
      stop_q    <= stop_d;
      ft_q      <= ft_d;
    end
  end

  // load sees the values written in the same clock that clears write-hold
  assign load_o     = wr_hold_q && !wr_hold_d;
  assign load_val_o = user_d;
  assign osc_run_o  = !stop_q;
  assign ft_en_o    = ft_q;

  always_comb begin
    case (ofs_i)
      OFS_CTRL: rdata_o = {wr_hold_q, rd_hold_q, user_q.cent};
      OFS_SEC:  rdata_o = {stop_q, user_q.sec};
      OFS_MIN:  rdata_o = {1'b0, user_q.min};
      OFS_HR:   rdata_o = {2'b0, user_q.hr};
      OFS_DAY:  rdata_o = {bat_flag_i, ft_q, 3'b0, user_q.day};
      OFS_DATE: rdata_o = {2'b0, user_q.date};
      OFS_MON:  rdata_o = {3'b0, user_q.mon};
      OFS_YR:   rdata_o = user_q.yr;
      default:  rdata_o = 8'h00;
    endcase
  end

  a_r7_snapshot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_hold_q) && !$past(wr_hold_q)) |-> $stable(user_q));

  a_r5_no_tracking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_hold_q) && !$past(wr_en_i)) |-> $stable(user_q));

endmodule

// File: rtl/tkr_bus.sv
module tkr_bus
  import tkr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PRE_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              bat_flag_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              mem_sel_o,
  output logic              ftest_o
);
  localparam int WIN_LSB = 3;

  logic       in_win, sel, rd_cyc, wr_cyc;
  logic [7:0] rdata;
  logic       load, osc_run, ft_en, tick;
  tk_time_t   load_val, live;
  tk_ofs_e    ofs;

  assign in_win = &addr_i[ADDR_W-1:WIN_LSB];
  assign ofs    = tk_ofs_e'(addr_i[WIN_LSB-1:0]);
  assign sel    = !ce_ni;
  assign rd_cyc = sel && !oe_ni && we_ni && in_win;
  assign wr_cyc = sel && !we_ni && in_win;

  assign data_oe_o = rd_cyc;
  assign data_o    = rd_cyc ? rdata : 8'h00;
  assign mem_sel_o = sel && !in_win;

  tkr_reg_file u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_cyc),
    .ofs_i      (ofs),
    .wdata_i    (data_i),
    .bat_flag_i (bat_flag_i),
    .live_i     (live),
    .rdata_o    (rdata),
    .load_o     (load),
    .load_val_o (load_val),
    .osc_run_o  (osc_run),
    .ft_en_o    (ft_en)
  );

  tkr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (osc_run),
    .clear_i (load),
    .ft_en_i (ft_en),
    .tick_o  (tick),
    .ftest_o (ftest_o)
  );

  tkr_time_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (load_val),
    .live_o     (live)
  );

  a_r2_bus_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_sel_o && data_oe_o));

  a_r4_min_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && ofs == OFS_MIN) |-> !data_o[7]);

endmodule

// File: tb/tkr_bus_test.sv
module tkr_bus_test;
  localparam int PRE_W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdat = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        bat = 1'b1;
  logic [7:0]  rdat;
  logic        doe, msel, ft;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tkr_bus #(.ADDR_W(13), .PRE_W(PRE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdat),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .bat_flag_i(bat),
    .data_o(rdat), .data_oe_o(doe), .mem_sel_o(msel), .ftest_o(ft)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    addr = {10'h3FF, o}; wdat = d; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [2:0] o, output logic [7:0] v);
    @(negedge clk);
    addr = {10'h3FF, o}; ce_n = 0; oe_n = 0; we_n = 1;
    #1 v = rdat;
    ce_n = 1; oe_n = 1;
  endtask

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dim(input int m, input int y, input int c);
    bit leap;
    leap = (y % 4 == 0) && (y != 0 || c % 4 == 0);
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic set_time(input logic [7:0] c, y, mo, d, dw, h, mi, s);
    wr(0, {2'b10, c[5:0]});
    wr(1, {1'b0, s[6:0]});
    wr(2, mi); wr(3, h); wr(4, {5'b0, dw[2:0]});
    wr(5, d);  wr(6, mo); wr(7, y);
    wr(0, {2'b00, c[5:0]});
  endtask

  task automatic chk_time(input string req, input logic [7:0] c, y, mo, d, dw, h, mi, s);
    logic [7:0] v;
    rd(0, v); chk(req, "ctrl",  v, {2'b00, c[5:0]});
    rd(1, v); chk(req, "sec",   v, s);
    rd(2, v); chk(req, "min",   v, mi);
    rd(3, v); chk(req, "hour",  v, h);
    rd(4, v); chk(req, "wday",  v, {bat, 4'b0, dw[2:0]});
    rd(5, v); chk(req, "date",  v, d);
    rd(6, v); chk(req, "month", v, mo);
    rd(7, v); chk(req, "year",  v, y);
  endtask

  // load, wait one second and a bit, compare
  task automatic step(input string req, input logic [7:0] c0, y0, m0, d0, w0, h0, i0, s0,
                      input logic [7:0] c1, y1, m1, d1, w1, h1, i1, s1);
    set_time(c0, y0, m0, d0, w0, h0, i0, s0);
    repeat (1100) @(negedge clk);
    chk_time(req, c1, y1, m1, d1, w1, h1, i1, s1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    chk("R13", "ftest", ft, 0);
    chk("R13", "mem_sel", msel, 0);
    chk_time("R13", 8'h20, 8'h00, 8'h01, 8'h01, 8'd1, 8'h00, 8'h00, 8'h00);

    // R1 / R2 decode sweep; data 0 keeps any write harmless
    wdat = 8'h00;
    for (int a = 13'h1FF0; a <= 13'h1FFF; a++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        addr = 13'(a); ce_n = s[2]; oe_n = s[1]; we_n = s[0];
        #1;
        chk("R2", $sformatf("oe a=%0h s=%0d", a, s), doe,
            (!s[2] && !s[1] && s[0] && a >= 13'h1FF8));
        chk("R1", $sformatf("msel a=%0h s=%0d", a, s), msel, (!s[2] && a < 13'h1FF8));
      end
    end
    @(negedge clk);
    addr = 13'h0000; ce_n = 0; oe_n = 0; we_n = 1; #1;
    chk("R1", "low addr msel", msel, 1); chk("R1", "low addr oe", doe, 0);
    ce_n = 1; oe_n = 1;

    // R4 masking of unused bits (W=1)
    wr(0, 8'hA0);
    wr(2, 8'hFF); rd(2, v); chk("R4", "min mask",  v, 8'h7F);
    wr(3, 8'hFF); rd(3, v); chk("R4", "hour mask", v, 8'h3F);
    wr(4, 8'h3F); rd(4, v); chk("R4", "wday mask", v, 8'h87);
    wr(5, 8'hFF); rd(5, v); chk("R4", "date mask", v, 8'h3F);
    wr(6, 8'hFF); rd(6, v); chk("R4", "mon mask",  v, 8'h1F);
    rd(0, v); chk("R3", "ctrl W bit", v, 8'hA0);

    // R5 no tracking while W=1
    wr(1, 8'h42);
    repeat (1500) @(negedge clk);
    rd(1, v); chk("R5", "held sec", v, 8'h42);

    // R6 load and prescaler restart
    set_time(8'h20, 8'h24, 8'h05, 8'h17, 8'd5, 8'h08, 8'h30, 8'h10);
    chk_time("R6", 8'h20, 8'h24, 8'h05, 8'h17, 8'd5, 8'h08, 8'h30, 8'h10);
    wr(1, 8'h33); rd(1, v); chk("R5", "write ignored W=0", v, 8'h10);
    repeat (975) @(negedge clk);
    rd(1, v); chk("R6", "no early tick", v, 8'h10);
    repeat (100) @(negedge clk);
    rd(1, v); chk("R6", "first tick", v, 8'h11);

    // R8 carries
    step("R8", 8'h20, 8'h23, 8'h03, 8'h10, 8'd2, 8'h10, 8'h15, 8'h59,
               8'h20, 8'h23, 8'h03, 8'h10, 8'd2, 8'h10, 8'h16, 8'h00);
    step("R8", 8'h20, 8'h23, 8'h03, 8'h10, 8'd2, 8'h10, 8'h59, 8'h59,
               8'h20, 8'h23, 8'h03, 8'h10, 8'd2, 8'h11, 8'h00, 8'h00);
    step("R8", 8'h19, 8'h99, 8'h12, 8'h31, 8'd7, 8'h23, 8'h59, 8'h59,
               8'h20, 8'h00, 8'h01, 8'h01, 8'd1, 8'h00, 8'h00, 8'h00);
    step("R8", 8'h39, 8'h99, 8'h12, 8'h31, 8'd6, 8'h23, 8'h59, 8'h59,
               8'h00, 8'h00, 8'h01, 8'h01, 8'd7, 8'h00, 8'h00, 8'h00);

    // R9 every month end in a common year
    for (int m = 1; m <= 12; m++) begin
      step("R9", 8'h20, 8'h23, bcd(m), bcd(dim(m, 23, 20)), 8'd3, 8'h23, 8'h59, 8'h59,
                 8'h20, (m == 12) ? 8'h24 : 8'h23, bcd(m % 12 + 1), 8'h01, 8'd4,
                 8'h00, 8'h00, 8'h00);
    end
    // R9 leap rules
    step("R9", 8'h20, 8'h24, 8'h02, 8'h28, 8'd1, 8'h23, 8'h59, 8'h59,
               8'h20, 8'h24, 8'h02, 8'h29, 8'd2, 8'h00, 8'h00, 8'h00);
    step("R9", 8'h20, 8'h24, 8'h02, 8'h29, 8'd1, 8'h23, 8'h59, 8'h59,
               8'h20, 8'h24, 8'h03, 8'h01, 8'd2, 8'h00, 8'h00, 8'h00);
    step("R9", 8'h20, 8'h00, 8'h02, 8'h28, 8'd1, 8'h23, 8'h59, 8'h59,
               8'h20, 8'h00, 8'h02, 8'h29, 8'd2, 8'h00, 8'h00, 8'h00);
    step("R9", 8'h19, 8'h00, 8'h02, 8'h28, 8'd1, 8'h23, 8'h59, 8'h59,
               8'h19, 8'h00, 8'h03, 8'h01, 8'd2, 8'h00, 8'h00, 8'h00);

    // R7 read snapshot
    set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'd3, 8'h10, 8'h20, 8'h30);
    wr(0, 8'h60);
    repeat (3300) @(negedge clk);
    rd(1, v); chk("R7", "frozen sec", v, 8'h30);
    rd(0, v); chk("R7", "ctrl R bit", v, 8'h60);
    wr(0, 8'h20);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R7", "released sec", v, 8'h33);

    // R10 oscillator stop
    set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'd3, 8'h10, 8'h20, 8'h40);
    wr(1, 8'h80);
    repeat (2500) @(negedge clk);
    rd(1, v); chk("R10", "stopped sec", v, 8'hC0);
    wr(1, 8'h00);
    repeat (1100) @(negedge clk);
    rd(1, v); chk("R10", "resumed sec", v, 8'h41);

    // R12 frequency test
    wr(4, 8'h40);
    rd(4, v); chk("R12", "ft bit", v[6], 1);
    @(negedge clk); prev = ft;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R12", "ft toggles", ft, !prev);
      prev = ft;
    end
    wr(1, 8'h80);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R12", "ft quiet when stopped", ft, 0);
    end
    wr(1, 8'h00); wr(4, 8'h00);
    @(negedge clk); chk("R12", "ft off", ft, 0);

    // R11 battery flag read-only
    bat = 1'b0;
    rd(4, v); chk("R11", "bf low", v[7], 0);
    wr(4, 8'h80);
    rd(4, v); chk("R11", "bf write ignored", v[7], 0);
    bat = 1'b1;
    rd(4, v); chk("R11", "bf high", v[7], 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule